// File: doc/BRIEF.md
# EDO DRAM Controller with Timed Refresh

This block connects a synchronous, single-word request port to an asynchronous 4M x 16 extended-data-out DRAM. A request carries a 22-bit word address, a write flag, 16-bit write data and two byte enables. The controller multiplexes the row half and then the column half of the address onto twelve shared address pins. It drives the active-low row strobe, the two byte-lane column strobes, write enable and output enable. On a read it registers the word the DRAM returns. Every DRAM interval is a parameter counted in clock cycles. The defaults are sized for a 10 ns clock.

After an access the row stays open. A later request to the same row is served as a page-mode access: only the column strobes toggle. A request to a different row closes the open row first, waits out the precharge and then opens the new row. A free-running timer raises a refresh request. That request wins over new traffic. The access in flight finishes, the row is closed, and a refresh cycle follows in which the column strobes fall before the row strobe, so that the device supplies the row from its own counter.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While it waits, the requester must hold the request fields stable. `req_ready` drops for as long as an access, a precharge or a refresh is in progress. Read data has no back-pressure: `rd_valid` is a single-cycle strobe and the requester must take `rd_data` in that cycle.

Top module: `edo_mem_ctrl`

## Requirements
- R1: The row address is `req_addr[21:10]` and is on `dram_addr` when the row strobe falls. The column address is `req_addr[9:0]`, zero-extended, and is on `dram_addr` when a column strobe falls.
- R2: `dram_we_n` is high for a read and low for a write. `dram_oe_n` is low only during the column window of a read and is never low while `dram_we_n` is low. Write data is driven with `dram_dq_oe` high whenever a column strobe falls for a write.
- R3: `dram_cas_l_n` strobes the lower byte (data bits 7:0, enabled by `req_be[0]`) and `dram_cas_h_n` strobes the upper byte (bits 15:8, enabled by `req_be[1]`). A write asserts only the lanes whose enable is 1, so a write with enables 00 leaves the word unchanged. A read asserts both lanes.
- R4: Read data is sampled at the end of the column access window and appears on `rd_data` with `rd_valid` high for exactly one cycle. Reads return in request order.
- R5: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low whenever a column strobe is low.
- R6: A request to the open row leaves `dram_ras_n` low. It is served by column strobes alone, with no new fall of the row strobe.
- R7: Before every fall of the row strobe, `dram_ras_n` has been high for at least `T_RP` cycles. A request to a different row closes the open row first.
- R8: A refresh drives both column strobes low before the row strobe falls, then holds the row strobe low for `T_RAS_REF` cycles. Refresh cycles begin at most `T_REFI` cycles apart plus the latency of one access. A raised refresh request stays pending until it is served.
- R9: A pending refresh takes priority over new requests. It starts only once the current access has finished and the row is closed, and no read is outstanding when it starts.
- R10: `dram_oe_n` is high in the cycle before a column strobe rises and in the cycle after it rises.
- R11: After reset, all DRAM strobes are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 22 | Word address: row in the upper 12 bits, column in the lower 10 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 is the lower byte, bit 1 the upper byte |
| rd_valid | output | 1 | Single-cycle read data strobe |
| rd_data | output | 16 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_l_n | output | 1 | Lower-byte column strobe, active low |
| dram_cas_h_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The assertions check on every cycle that precharge before each row-strobe fall lasts at least `T_RP` cycles, that write and output enable are never both low, and that output enable is high around each column-strobe rise. They also check that refresh strobes both lanes before the row strobe, that a raised refresh stays pending, that the read strobe lasts one cycle, and that ready is never high while a column strobe is low. Some behaviour can only be shown by the bench's scenarios against a behavioural DRAM model and a shadow memory. This covers the row and column address split, byte-lane masking seen through readback, the single row opening of a same-row burst, one opening per request when rows alternate, and the spacing of refreshes under idle and saturated traffic.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,    // row closed and precharged
    ST_ROWSET,  // row address set up, row strobe still high
    ST_RCD,     // row strobe low, waiting for row-to-column delay
    ST_COLSET,  // column address and write data set up
    ST_CAS,     // column strobe window
    ST_CEND,    // column strobe still low, output enable released
    ST_OPEN,    // row held open, waiting for a page hit
    ST_PRE,     // row strobe high for precharge
    ST_REFCAS,  // refresh: column strobes low before the row strobe
    ST_REFRAS   // refresh: row strobe low
  } seq_state_t;

  typedef enum logic [1:0] {
    NX_IDLE,
    NX_ROW,
    NX_REF
  } after_pre_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int T_REFI = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int TW = $clog2(T_REFI + 1);

  logic [TW-1:0] tick;
  logic          fire;

  assign fire = (tick == TW'(T_REFI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= '0;
      ref_pend <= 1'b0;
    end else begin
      tick <= fire ? '0 : tick + 1'b1;
      if (fire)         ref_pend <= 1'b1;
      else if (ref_ack) ref_pend <= 1'b0;
    end
  end

  AST_REF_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend && !ref_ack |=> ref_pend); // R8

endmodule

// File: rtl/edo_req_latch.sv
module edo_req_latch #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic                    req_write,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_be,
  input  logic                    addr_col,
  output logic                    row_hit,
  output logic                    lat_write,
  output logic [DATA_W/8-1:0]     lat_be,
  output logic [DATA_W-1:0]       dq_out,
  output logic [ROW_W-1:0]        dram_addr
);
  localparam int ADDR_W = ROW_W + COL_W;

  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_row   <= '0;
      lat_col   <= '0;
      lat_write <= 1'b0;
      lat_be    <= '0;
      dq_out    <= '0;
    end else if (load) begin
      lat_row   <= req_addr[ADDR_W-1:COL_W];
      lat_col   <= req_addr[COL_W-1:0];
      lat_write <= req_write;
      lat_be    <= req_be;
      dq_out    <= req_wdata;
    end
  end

  // the latched row equals the open row whenever the sequencer holds a row open
  assign row_hit   = (req_addr[ADDR_W-1:COL_W] == lat_row);
  assign dram_addr = addr_col ? ROW_W'(lat_col) : lat_row;

endmodule

// File: rtl/edo_lane_cas.sv
module edo_lane_cas #(
  parameter int LANES = 2
) (
  input  logic             cas_act,
  input  logic             ref_cyc,
  input  logic             write,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] cas_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cas_n[i] = !(cas_act && (ref_cyc || !write || be[i]));
  end
endmodule

// File: rtl/edo_sequencer.sv
module edo_sequencer
  import edo_ctrl_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_CSR     = 1,
  parameter int T_RAS_REF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic row_hit,
  input  logic ref_pend,
  input  logic lat_write,
  output logic req_ready,
  output logic load,
  output logic ref_ack,
  output logic ras_n,
  output logic cas_act,
  output logic ref_cyc,
  output logic addr_col,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic cap
);
  localparam int TMAX  = imax(imax(imax(T_RCD, T_CAS), imax(T_RP, T_CSR)), T_RAS_REF);
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_t       state, state_nx;
  after_pre_t       goal, goal_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             cnt_done;
  logic             wr_phase;

  assign cnt_done = (cnt == '0);

  always_comb begin
    state_nx = state;
    goal_nx  = goal;
    cnt_nx   = cnt_done ? cnt : cnt - 1'b1;
    load     = 1'b0;
    ref_ack  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ref_pend) begin
          state_nx = ST_REFCAS;
          cnt_nx   = CNT_W'(T_CSR - 1);
          ref_ack  = 1'b1;
        end else if (req_valid) begin
          load     = 1'b1;
          state_nx = ST_ROWSET;
        end
      end
      ST_ROWSET: begin
        state_nx = ST_RCD;
        cnt_nx   = CNT_W'(T_RCD - 1);
      end
      ST_RCD: if (cnt_done) state_nx = ST_COLSET;
      ST_COLSET: begin
        state_nx = ST_CAS;
        cnt_nx   = CNT_W'(T_CAS - 1);
      end
      ST_CAS:  if (cnt_done) state_nx = ST_CEND;
      ST_CEND: state_nx = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend) begin
          state_nx = ST_PRE;
          goal_nx  = NX_REF;
          cnt_nx   = CNT_W'(T_RP - 1);
        end else if (req_valid) begin
          load = 1'b1;
          if (row_hit) begin
            state_nx = ST_COLSET;
          end else begin
            state_nx = ST_PRE;
            goal_nx  = NX_ROW;
            cnt_nx   = CNT_W'(T_RP - 1);
          end
        end
      end
      ST_PRE: begin
        if (cnt_done) begin
          unique case (goal)
            NX_ROW: state_nx = ST_ROWSET;
            NX_REF: begin
              state_nx = ST_REFCAS;
              cnt_nx   = CNT_W'(T_CSR - 1);
              ref_ack  = 1'b1;
            end
            default: state_nx = ST_IDLE;
          endcase
        end
      end
      ST_REFCAS: begin
        if (cnt_done) begin
          state_nx = ST_REFRAS;
          cnt_nx   = CNT_W'(T_RAS_REF - 1);
        end
      end
      ST_REFRAS: begin
        if (cnt_done) begin
          state_nx = ST_PRE;
          goal_nx  = NX_IDLE;
          cnt_nx   = CNT_W'(T_RP - 1);
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      goal  <= NX_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      goal  <= goal_nx;
      cnt   <= cnt_nx;
    end
  end

  // pin decode from the registered state
  assign ras_n    = !(state inside {ST_RCD, ST_COLSET, ST_CAS, ST_CEND, ST_OPEN, ST_REFRAS});
  assign cas_act  = state inside {ST_CAS, ST_CEND, ST_REFCAS, ST_REFRAS};
  assign ref_cyc  = state inside {ST_REFCAS, ST_REFRAS};
  assign addr_col = state inside {ST_COLSET, ST_CAS, ST_CEND, ST_OPEN};
  assign wr_phase = lat_write && (state inside {ST_COLSET, ST_CAS, ST_CEND});
  assign we_n     = !wr_phase;
  assign dq_oe    = wr_phase;
  assign oe_n     = !(!lat_write && state == ST_CAS);
  assign cap      = !lat_write && state == ST_CAS && cnt_done;
  assign req_ready = (state == ST_IDLE || state == ST_OPEN) && !ref_pend;

  // run length of the row strobe high, for the precharge check
  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_run <= CNT_W'(T_RP);
    else if (!ras_n)                  hi_run <= '0;
    else if (hi_run < CNT_W'(T_RP))   hi_run <= hi_run + 1'b1;
  end

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_run >= CNT_W'(T_RP)); // R7
  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n); // R2
  AST_OE_AROUND_CAS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_act) |-> oe_n && $past(oe_n)); // R10
  AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cas_act); // R5
  AST_REF_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> ras_n && !cas_act); // R9

endmodule

// File: rtl/edo_mem_ctrl.sv
module edo_mem_ctrl #(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_CSR     = 1,
  parameter int T_RAS_REF = 5,
  parameter int T_REFI    = 1560
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic                    req_write,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [DATA_W/8-1:0]     req_be,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic [ROW_W-1:0]        dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_cas_l_n,
  output logic                    dram_cas_h_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int LANES = DATA_W / 8;

  logic             row_hit, lat_write, load, ref_pend, ref_ack;
  logic             cas_act, ref_cyc, addr_col, cap;
  logic [LANES-1:0] lat_be, cas_n;

  edo_refresh_timer #(.T_REFI(T_REFI)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  edo_req_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
    .addr_col(addr_col), .row_hit(row_hit), .lat_write(lat_write),
    .lat_be(lat_be), .dq_out(dram_dq_out), .dram_addr(dram_addr)
  );

  edo_sequencer #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS_REF(T_RAS_REF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .row_hit(row_hit),
    .ref_pend(ref_pend), .lat_write(lat_write), .req_ready(req_ready),
    .load(load), .ref_ack(ref_ack), .ras_n(dram_ras_n), .cas_act(cas_act),
    .ref_cyc(ref_cyc), .addr_col(addr_col), .we_n(dram_we_n),
    .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .cap(cap)
  );

  edo_lane_cas #(.LANES(LANES)) u_lanes (
    .cas_act(cas_act), .ref_cyc(ref_cyc), .write(lat_write), .be(lat_be), .cas_n(cas_n)
  );

  assign dram_cas_l_n = cas_n[0];
  assign dram_cas_h_n = cas_n[LANES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= dram_dq_in;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_CBR_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) && !dram_cas_l_n |-> !dram_cas_h_n && $past(!dram_cas_l_n)); // R8

endmodule

// File: tb/edo_mem_ctrl_tb.sv
module edo_mem_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_REFI     = 300;
  localparam int T_RP       = 3;
  localparam int SLACK      = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic [11:0] dram_addr;
  logic        dram_ras_n, dram_cas_l_n, dram_cas_h_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = 16'hDEAD;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_mem_ctrl #(.T_REFI(T_REFI), .T_RP(T_RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_l_n(dram_cas_l_n),
    .dram_cas_h_n(dram_cas_h_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // shadow memory (reference) and behavioural DRAM contents
  logic [15:0] ref_mem [logic [21:0]];
  logic [15:0] dmem    [logic [21:0]];
  logic [15:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [15:0] ref_get(input logic [21:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] dmem_get(input logic [21:0] a);
    return dmem.exists(a) ? dmem[a] : 16'h0000;
  endfunction

  logic [21:0] cur_addr = '0;
  logic        cur_write = 1'b0;
  logic [1:0]  cur_be = '0;

  task automatic issue(input logic [21:0] a, input logic wr, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    logic [15:0] old;
    req_addr = a; req_write = wr; req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    cur_addr = a; cur_write = wr; cur_be = wr ? be : 2'b11;
    if (wr) begin
      old = ref_get(a);
      if (be[0]) old[7:0]  = d[7:0];
      if (be[1]) old[15:8] = d[15:8];
      ref_mem[a] = old;
    end else begin
      exp_q.push_back(ref_get(a));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // per-clock monitor: DRAM model plus reference comparison
  int  cyc = 0, last_cbr = 0, cbr_n = 0, ras_falls = 0, hi_len = 100;
  logic p_ras = 1'b1, p_casl = 1'b1, p_cash = 1'b1, p_oe = 1'b1;
  logic [11:0] row_q = '0;
  logic [9:0]  col_q = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        if (!dram_cas_l_n || !dram_cas_h_n) begin
          chk(!dram_cas_l_n && !dram_cas_h_n && !p_casl && !p_cash, "R8 cbr strobes", {dram_cas_h_n, dram_cas_l_n}, 0);
          chk(cyc - last_cbr <= T_REFI + SLACK, "R8 refresh gap", cyc - last_cbr, T_REFI + SLACK);
          chk(exp_q.size() == 0, "R9 read outstanding at refresh", exp_q.size(), 0);
          last_cbr = cyc;
          cbr_n++;
        end else begin
          row_q = dram_addr;
          ras_falls++;
          chk(dram_addr == cur_addr[21:10], "R1 row address", dram_addr, cur_addr[21:10]);
          chk(hi_len >= T_RP, "R7 precharge", hi_len, T_RP);
        end
      end
      if (dram_ras_n) hi_len++; else hi_len = 0;
      if (!dram_ras_n && ((p_casl && !dram_cas_l_n) || (p_cash && !dram_cas_h_n))) begin
        logic [15:0] w;
        col_q = dram_addr[9:0];
        chk(dram_addr == {2'b00, cur_addr[9:0]}, "R1 column address", dram_addr, cur_addr[9:0]);
        chk({!dram_cas_h_n, !dram_cas_l_n} == cur_be, "R3 lane strobes", {!dram_cas_h_n, !dram_cas_l_n}, cur_be);
        chk(dram_we_n == !cur_write, "R2 write enable", dram_we_n, !cur_write);
        if (!dram_we_n) begin
          chk(dram_dq_oe, "R2 data drive", dram_dq_oe, 1);
          w = dmem_get({row_q, col_q});
          if (!dram_cas_l_n) w[7:0]  = dram_dq_out[7:0];
          if (!dram_cas_h_n) w[15:8] = dram_dq_out[15:8];
          dmem[{row_q, col_q}] = w;
        end
      end
      dram_dq_in = (!dram_oe_n && dram_we_n && !dram_ras_n && (!dram_cas_l_n || !dram_cas_h_n))
                   ? dmem_get({row_q, col_q}) : 16'hDEAD;
      chk(dram_we_n || dram_oe_n, "R2 we/oe exclusive", {dram_we_n, dram_oe_n}, 2'b10);
      if ((!p_casl && dram_cas_l_n) || (!p_cash && dram_cas_h_n))
        chk(dram_oe_n && p_oe, "R10 oe around cas rise", {p_oe, dram_oe_n}, 2'b11);
      if (!dram_cas_l_n || !dram_cas_h_n)
        chk(!req_ready, "R5 ready during strobe", req_ready, 0);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected rd_valid", rd_data, 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
      p_ras = dram_ras_n; p_casl = dram_cas_l_n; p_cash = dram_cas_h_n; p_oe = dram_oe_n;
    end
  end

  task automatic wait_cbr();
    int n0 = cbr_n;
    while (cbr_n == n0) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready", req_ready, 1);
    chk({dram_ras_n, dram_cas_l_n, dram_cas_h_n, dram_we_n, dram_oe_n} == 5'b11111, "R11 strobes",
        {dram_ras_n, dram_cas_l_n, dram_cas_h_n, dram_we_n, dram_oe_n}, 5'b11111);
    chk(!rd_valid && !dram_dq_oe, "R11 valid/drive", {rd_valid, dram_dq_oe}, 0);

    // R1 R2 R4 basic write and readback across distinct rows and columns
    issue(22'h2ABCD, 1, 16'hBEEF, 2'b11, "R4 basic");
    issue(22'h00001, 1, 16'h1357, 2'b11, "R4 basic");
    issue(22'h3FFFFF, 1, 16'hC0DE, 2'b11, "R4 basic");
    issue(22'h2ABCD, 0, 0, 2'b00, "R4 readback A");
    issue(22'h00001, 0, 0, 2'b00, "R4 readback B");
    issue(22'h3FFFFF, 0, 0, 2'b00, "R4 readback C");
    drain();

    // R3 byte lanes
    issue(22'h01234, 1, 16'hAAAA, 2'b11, "R3");
    issue(22'h01234, 1, 16'h1234, 2'b01, "R3");
    issue(22'h01234, 0, 0, 2'b00, "R3 lower lane only");
    issue(22'h01234, 1, 16'h5678, 2'b10, "R3");
    issue(22'h01234, 0, 0, 2'b00, "R3 upper lane only");
    issue(22'h01234, 1, 16'hFFFF, 2'b00, "R3");
    issue(22'h01234, 0, 0, 2'b00, "R3 no lane write ignored");
    drain();

    // R6 page burst: one row opening for a same-row burst
    begin
      int f0;
      wait_cbr();
      f0 = ras_falls;
      for (int i = 0; i < 8; i++) issue({12'h155, 10'(i)}, 1, 16'(16'hA500 + i), 2'b11, "R6");
      for (int i = 0; i < 8; i++) issue({12'h155, 10'(i)}, 0, 0, 2'b00, "R6 page readback");
      drain();
      chk(ras_falls - f0 == 1, "R6 row openings in burst", ras_falls - f0, 1);
    end

    // R7 alternating rows: every request reopens
    begin
      int f0;
      wait_cbr();
      f0 = ras_falls;
      for (int i = 0; i < 6; i++) issue({12'(12'h200 + (i % 2)), 10'h3}, (i < 2), 16'(16'h7700 + i), 2'b11, "R7 miss readback");
      drain();
      chk(ras_falls - f0 == 6, "R7 reopen per miss", ras_falls - f0, 6);
    end

    // R8 idle refreshes
    begin
      int c0 = cbr_n;
      repeat (3 * T_REFI) @(negedge clk);
      chk(cbr_n - c0 >= 2, "R8 idle refresh count", cbr_n - c0, 2);
    end

    // R9 saturated mixed traffic with refresh preemption
    begin
      int c0 = cbr_n;
      logic [31:0] r = 32'h1ACE_B00C;
      for (int i = 0; i < 500; i++) begin
        r = r * 32'd1103515245 + 32'd12345;
        issue({12'(12'h100 + r[21:20]), 7'h0, r[11:9]}, r[12], r[31:16], r[14:13], "R9 stream readback");
      end
      drain();
      chk(cbr_n - c0 >= 5, "R9 refresh under load", cbr_n - c0, 5);
    end
    chk(cyc - last_cbr <= T_REFI + SLACK, "R8 final gap", cyc - last_cbr, T_REFI + SLACK);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule